// File: doc/BRIEF.md
# Photon Detector Sampler and Packer

This block is the receive front end for a pair of single-photon detectors. It serves two purposes: as a source of random bits, and as the sampling stage of a key receiver. The pulses from the two detectors and from an external trigger line are asynchronous to the system clock. Each line first passes through a flip-flop synchronizer and then a rising-edge detector, so timing resolution is one clock period. Time is divided into fixed sampling windows. When exactly one detector fires in a window, that window yields one bit, and the bit value names the line that fired. Windows with no event are dropped. Windows where both lines fired are also dropped.

Bits are packed into 32-bit words and written out at successive buffer addresses. An interrupt marks the writes that fill the first half of the buffer and the writes that fill its end. In free-running mode, capture follows an enable level. In triggered mode, capture starts only on a trigger edge and collects a fixed burst of bits. The first bit of each burst is copied to an auxiliary output that steers an external optical element. When capture stops, a partly filled word is flushed, and its count of valid bits is reported with it.

Top module: `photon_sampler_top`

## Requirements
- R1: After reset, `wr_en`, `irq` and `aux_out` are low, and the first word written goes to address 0.
- R2: Each detector line passes through a two-stage synchronizer and a rising-edge detector. Within one window, a line counts as having fired once, however long its pulse is held and however many pulses it gives.
- R3: A window lasts WIN clock cycles. If only line `det_a` fired, the window yields bit 0. If only `det_b` fired, it yields bit 1. A window with no event, or with both lines fired, yields no bit.
- R4: Bits fill a word LSB-first, so bit k of a word is the k-th bit captured for it. A full word is written with `wr_cnt` = 32.
- R5: Words go to successive addresses. After address DEPTH-1, the next address is 0.
- R6: `irq` is high for exactly the cycle of a write to address DEPTH/2-1 (with `irq_end` = 0) or to address DEPTH-1 (with `irq_end` = 1). It is low at all other times.
- R7: When capture stops, a partly filled word is written with its unused high bits zero and `wr_cnt` equal to its valid-bit count. An empty word is not written. Events in the unfinished window are discarded.
- R8: In free-running mode (`trig_mode` = 0), capture runs while `cap_en` is high, and the trigger line has no effect.
- R9: In triggered mode (`trig_mode` = 1), no bits are captured before a trigger rising edge, and `cap_en` is ignored. After the trigger, exactly BURST bits are captured, then capture stops and flushes.
- R10: The first bit captured after each accepted trigger drives `aux_out`, which holds until the next burst. In free-running mode, `aux_out` does not change.
- R11: A trigger edge that arrives while a burst is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| det_a | input | 1 | Detector line A, asynchronous |
| det_b | input | 1 | Detector line B, asynchronous |
| trig_in | input | 1 | External trigger line, asynchronous |
| trig_mode | input | 1 | 0 = free-running capture, 1 = triggered bursts |
| cap_en | input | 1 | Capture enable level for free-running mode |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | $clog2(DEPTH) | Buffer address of the word |
| wr_data | output | WORD_W | Packed word |
| wr_cnt | output | $clog2(WORD_W+1) | Number of valid bits in the word |
| irq | output | 1 | Buffer boundary interrupt pulse |
| irq_end | output | 1 | 0 = half-buffer boundary, 1 = end of buffer |
| aux_out | output | 1 | Auxiliary line driven by the first bit of a burst |

## Verification
The hardest thing to reach from the ports is a detector event that falls inside one chosen window. The synchronizer adds latency, and window boundaries are set by when capture starts. The stimulus therefore drives capture start and every detector edge on falling clock edges, counted from the enable or trigger edge. It allows for the two synchronizer stages, and it keeps every event clear of window borders, so each window's outcome is known. A trigger pulse is placed in the second window of a burst, while the burst is certain to still be running, to reach the ignored-trigger case. A small buffer depth makes address wrap and both interrupt kinds occur several times.

// File: rtl/psp_pkg.sv
package psp_pkg;
  // one sampling-window result: vld marks a usable window, val is the bit
  typedef struct packed {
    logic vld;
    logic val;
  } smp_t;

  localparam int unsigned N_LINES = 3;
  localparam int unsigned LINE_A  = 0;
  localparam int unsigned LINE_B  = 1;
  localparam int unsigned LINE_T  = 2;
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  // single-cycle pulse per rising edge of the synchronized level
  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/psp_window.sv
module psp_window
  import psp_pkg::*;
#(
  parameter int unsigned WIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic hit_a,
  input  logic hit_b,
  output smp_t smp
);
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [CW-1:0] wcnt;
  logic          seen_a, seen_b;
  logic          any_a, any_b, last;

  always_comb begin
    any_a = seen_a | hit_a;
    any_b = seen_b | hit_b;
    last  = (wcnt == CW'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      wcnt    <= '0;
      seen_a  <= 1'b0;
      seen_b  <= 1'b0;
      smp.vld <= 1'b0;
      smp.val <= 1'b0;
    end else if (last) begin
      wcnt    <= '0;
      seen_a  <= 1'b0;
      seen_b  <= 1'b0;
      smp.vld <= any_a ^ any_b;
      smp.val <= any_b;
    end else begin
      wcnt    <= wcnt + 1'b1;
      seen_a  <= any_a;
      seen_b  <= any_b;
      smp.vld <= 1'b0;
    end
  end
endmodule

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int unsigned BURST = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_mode,
  input  logic cap_en,
  input  logic trig_hit,
  input  smp_t smp,
  output logic active,
  output logic stop,
  output logic aux
);
  localparam int unsigned BW = $clog2(BURST + 1);

  logic [BW-1:0] nbits;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      stop   <= 1'b0;
      aux    <= 1'b0;
      pend   <= 1'b0;
      nbits  <= '0;
    end else begin
      stop <= 1'b0;
      if (!trig_mode) begin
        active <= cap_en;
        stop   <= active & ~cap_en;
        pend   <= 1'b0;
      end else if (!active) begin
        if (trig_hit) begin
          active <= 1'b1;
          nbits  <= '0;
          pend   <= 1'b1;
        end
      end else if (smp.vld) begin
        if (pend) begin
          aux  <= smp.val;
          pend <= 1'b0;
        end
        if (nbits == BW'(BURST - 1)) begin
          active <= 1'b0;
          stop   <= 1'b1;
        end else begin
          nbits <= nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psp_packer.sv
module psp_packer
  import psp_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 1024
) (
  input  logic                         clk,
  input  logic                         rst,
  input  smp_t                         smp,
  input  logic                         flush,
  output logic                         wr_en,
  output logic [$clog2(DEPTH)-1:0]     wr_addr,
  output logic [WORD_W-1:0]            wr_data,
  output logic [$clog2(WORD_W+1)-1:0]  wr_cnt,
  output logic                         irq,
  output logic                         irq_end
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CW   = $clog2(WORD_W + 1);
  localparam int unsigned IW   = $clog2(WORD_W);
  localparam int unsigned HALF = DEPTH / 2;

  logic [WORD_W-1:0] shreg, nxt_word;
  logic [CW-1:0]     fill, nxt_fill;
  logic [AW-1:0]     waddr;
  logic              emit;

  always_comb begin
    nxt_word = shreg;
    nxt_fill = fill;
    if (smp.vld) begin
      nxt_word[fill[IW-1:0]] = smp.val;
      nxt_fill               = fill + 1'b1;
    end
    emit = (nxt_fill == CW'(WORD_W)) || (flush && (nxt_fill != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      fill    <= '0;
      waddr   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_cnt  <= '0;
      irq     <= 1'b0;
      irq_end <= 1'b0;
    end else begin
      wr_en <= emit;
      if (emit) begin
        wr_data <= nxt_word;
        wr_cnt  <= nxt_fill;
        wr_addr <= waddr;
        irq     <= (waddr == AW'(HALF - 1)) || (waddr == AW'(DEPTH - 1));
        irq_end <= (waddr == AW'(DEPTH - 1));
        waddr   <= (waddr == AW'(DEPTH - 1)) ? '0 : waddr + 1'b1;
        shreg   <= '0;
        fill    <= '0;
      end else begin
        shreg   <= nxt_word;
        fill    <= nxt_fill;
        irq     <= 1'b0;
        irq_end <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/photon_sampler_top.sv
module photon_sampler_top
  import psp_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned DEPTH       = 1024,
  parameter int unsigned WIN         = 8,
  parameter int unsigned BURST       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         det_a,
  input  logic                         det_b,
  input  logic                         trig_in,
  input  logic                         trig_mode,
  input  logic                         cap_en,
  output logic                         wr_en,
  output logic [$clog2(DEPTH)-1:0]     wr_addr,
  output logic [WORD_W-1:0]            wr_data,
  output logic [$clog2(WORD_W+1)-1:0]  wr_cnt,
  output logic                         irq,
  output logic                         irq_end,
  output logic                         aux_out
);
  logic [N_LINES-1:0] raw_lines, hit_lines;
  logic               active_w, stop_w, trig_hit_w;
  smp_t               smp_w;

  assign raw_lines[LINE_A] = det_a;
  assign raw_lines[LINE_B] = det_b;
  assign raw_lines[LINE_T] = trig_in;

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    psp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_lines[i]),
      .rise     (hit_lines[i])
    );
  end

  assign trig_hit_w = hit_lines[LINE_T];

  psp_window #(.WIN(WIN)) u_window (
    .clk    (clk),
    .rst    (rst),
    .active (active_w),
    .hit_a  (hit_lines[LINE_A]),
    .hit_b  (hit_lines[LINE_B]),
    .smp    (smp_w)
  );

  psp_ctrl #(.BURST(BURST)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .trig_mode (trig_mode),
    .cap_en    (cap_en),
    .trig_hit  (trig_hit_w),
    .smp       (smp_w),
    .active    (active_w),
    .stop      (stop_w),
    .aux       (aux_out)
  );

  psp_packer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_packer (
    .clk     (clk),
    .rst     (rst),
    .smp     (smp_w),
    .flush   (stop_w),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_cnt  (wr_cnt),
    .irq     (irq),
    .irq_end (irq_end)
  );
endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 1024
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         trig_mode,
  input logic                         wr_en,
  input logic [$clog2(DEPTH)-1:0]     wr_addr,
  input logic [$clog2(WORD_W+1)-1:0]  wr_cnt,
  input logic                         irq,
  input logic                         irq_end,
  input logic                         aux_out,
  input logic                         active,
  input logic                         stop,
  input logic                         trig_hit
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CW   = $clog2(WORD_W + 1);
  localparam int unsigned HALF = DEPTH / 2;

  logic [AW-1:0] exp_a;
  always_ff @(posedge clk) begin
    if (rst) exp_a <= '0;
    else if (wr_en) exp_a <= (exp_a == AW'(DEPTH - 1)) ? '0 : exp_a + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_cnt != '0 && wr_cnt <= CW'(WORD_W)));

  // R7
  partial_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_cnt != CW'(WORD_W)) |-> $past(stop));

  // R5
  addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == exp_a));

  // R6
  irq_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> wr_en);

  // R6
  irq_pos_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((wr_addr == AW'(HALF - 1) && !irq_end) || (wr_addr == AW'(DEPTH - 1) && irq_end)));

  // R9
  trig_start_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_mode && $rose(active)) |-> $past(trig_hit));

  // R10
  aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_mode && !$past(trig_mode)) |-> $stable(aux_out));
endmodule

bind photon_sampler_top psp_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .trig_mode (trig_mode),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_cnt    (wr_cnt),
  .irq       (irq),
  .irq_end   (irq_end),
  .aux_out   (aux_out),
  .active    (active_w),
  .stop      (stop_w),
  .trig_hit  (trig_hit_w)
);

// File: tb/photon_sampler_top_tb.sv
`timescale 1ns/1ps
module photon_sampler_top_tb_top;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 8;
  localparam int WIN    = 8;
  localparam int BURST  = 5;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(WORD_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_a = 1'b0, det_b = 1'b0, trig_in = 1'b0, trig_mode = 1'b0, cap_en = 1'b0;
  logic              wr_en, irq, irq_end, aux_out;
  logic [AW-1:0]     wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [CW-1:0]     wr_cnt;

  always #2.5 clk = ~clk;

  photon_sampler_top #(.WORD_W(WORD_W), .DEPTH(DEPTH), .WIN(WIN), .BURST(BURST), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .det_a(det_a), .det_b(det_b), .trig_in(trig_in),
    .trig_mode(trig_mode), .cap_en(cap_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_cnt(wr_cnt), .irq(irq), .irq_end(irq_end), .aux_out(aux_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  int exp_a = 0;
  logic [WORD_W-1:0] exp_d[$], obs_d[$];
  int exp_c[$], obs_c[$];
  bit bitq[$];

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // write monitor: addresses and interrupts (R5, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        logic [1:0] ei;
        obs_d.push_back(wr_data);
        obs_c.push_back(int'(wr_cnt));
        check("R5", "write address", 64'(wr_addr), 64'(exp_a));
        ei = (exp_a == DEPTH - 1) ? 2'b11 : (exp_a == DEPTH / 2 - 1) ? 2'b10 : 2'b00;
        check("R6", "irq/irq_end", 64'({irq, (irq & irq_end)}), 64'(ei));
        exp_a = (exp_a + 1) % DEPTH;
      end else if (irq) begin
        check("R6", "irq without write", 64'(irq), 64'(0));
      end
    end
  end

  // one window of WIN steps; kind selects the detector pattern (R2, R3)
  task automatic run_win(input int kind, input bit tp, output bit v, output bit b);
    logic [7:0] pa, pb;
    case (kind)
      1: begin pa = 8'b0000_0110; pb = 8'b0; end          // A only
      2: begin pa = 8'b0;         pb = 8'b0000_1100; end  // B only
      3: begin pa = 8'b0000_0110; pb = 8'b0001_1000; end  // both, staggered
      4: begin pa = 8'b0011_0011; pb = 8'b0; end          // A twice
      5: begin pa = 8'b0;         pb = 8'b0001_1111; end  // B held long
      6: begin pa = 8'b0000_1100; pb = 8'b0000_1100; end  // both, same cycle
      default: begin pa = 8'b0; pb = 8'b0; end
    endcase
    v = (kind == 1) || (kind == 2) || (kind == 4) || (kind == 5);
    b = (kind == 2) || (kind == 5);
    for (int j = 0; j < WIN; j++) begin
      det_a   = pa[j];
      det_b   = pb[j];
      trig_in = tp && (j < 2);
      @(negedge clk);
    end
  endtask

  task automatic pack_expected(input bit flush);
    while (bitq.size() >= WORD_W) begin
      logic [WORD_W-1:0] w = '0;
      for (int k = 0; k < WORD_W; k++) w[k] = bitq.pop_front();
      exp_d.push_back(w);
      exp_c.push_back(WORD_W);
    end
    if (flush && bitq.size() > 0) begin
      logic [WORD_W-1:0] w = '0;
      int n = bitq.size();
      for (int k = 0; k < n; k++) w[k] = bitq.pop_front();
      exp_d.push_back(w);
      exp_c.push_back(n);
    end
  endtask

  task automatic compare_words(input string req);
    int n;
    check(req, "word count", 64'(obs_d.size()), 64'(exp_d.size()));
    n = (obs_d.size() < exp_d.size()) ? obs_d.size() : exp_d.size();
    for (int i = 0; i < n; i++) begin
      check(req, "word data", 64'(obs_d[i]), 64'(exp_d[i]));
      check(req, "valid count", 64'(obs_c[i]), 64'(exp_c[i]));
    end
    obs_d.delete(); obs_c.delete(); exp_d.delete(); exp_c.delete();
  endtask

  // free-running capture; style: 0 random, 1 alternating A/B, 2 no-bit kinds, 3 repeated/long pulses
  task automatic free_run(input int nwin, input int style, input bit tp0);
    bit v, b;
    int k;
    @(negedge clk); cap_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < nwin; i++) begin
      case (style)
        1: k = (i % 2 == 0) ? 1 : 2;
        2: k = (i % 3 == 0) ? 0 : (i % 3 == 1) ? 3 : 6;
        3: k = (i % 2 == 0) ? 4 : 5;
        default: k = $urandom_range(0, 6);
      endcase
      run_win(k, tp0 && (i == 0), v, b);
      if (v) bitq.push_back(b);
    end
    cap_en = 1'b0;
    run_win(1, 1'b0, v, b);      // unfinished window: discarded (R7)
    repeat (3) @(negedge clk);
    pack_expected(1'b1);
  endtask

  // triggered burst; mid_trig places a second trigger in window 1 (R11)
  task automatic trig_run(input int nwin, input bit mid_trig, output bit first_bit);
    bit v, b;
    int k, cnt;
    cnt = 0;
    first_bit = 1'b0;
    trig_in = 1'b1; @(negedge clk);
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nwin; i++) begin
      k = (i % 3 == 2) ? $urandom_range(0, 6) : $urandom_range(1, 2);
      run_win(k, mid_trig && (i == 1), v, b);
      if (v && cnt < BURST) begin
        if (cnt == 0) first_bit = b;
        bitq.push_back(b);
        cnt++;
      end
    end
    repeat (3) @(negedge clk);
    pack_expected(1'b1);
  endtask

  initial begin
    bit v, b, fb1, fb2;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "wr_en after reset", 64'(wr_en), 64'(0));
    check("R1", "irq after reset", 64'(irq), 64'(0));
    check("R1", "aux_out after reset", 64'(aux_out), 64'(0));

    // R3 R4 R7: long random capture with flush
    free_run(300, 0, 1'b0);
    compare_words("R3/R4/R7 random");

    // R4: exactly one full word, alternating bits, nothing to flush
    free_run(32, 1, 1'b0);
    compare_words("R4 full word");

    // R3 R7: windows without a usable bit give no write
    free_run(6, 2, 1'b0);
    compare_words("R7 empty flush");

    // R2: repeated and held pulses count once per line
    free_run(10, 3, 1'b0);
    compare_words("R2 pulse counting");

    // R8: trigger during free capture has no effect
    free_run(12, 0, 1'b1);
    compare_words("R8 trigger ignored");

    // R8: trigger without enable starts nothing
    trig_in = 1'b1; repeat (2) @(negedge clk); trig_in = 1'b0;
    for (int i = 0; i < 3; i++) run_win(1, 1'b0, v, b);
    compare_words("R8 no enable");

    // R5 R6: several short captures to wrap the buffer
    for (int r = 0; r < 8; r++) free_run(4, 0, 1'b0);
    compare_words("R5/R6 wrap");

    // R9: triggered mode ignores cap_en before a trigger
    @(negedge clk); trig_mode = 1'b1; cap_en = 1'b1;
    for (int i = 0; i < 4; i++) run_win(2, 1'b0, v, b);
    cap_en = 1'b0;
    repeat (3) @(negedge clk);
    compare_words("R9 before trigger");

    // R9 R10: burst of BURST bits, aux from its first bit
    trig_run(12, 1'b0, fb1);
    compare_words("R9 burst");
    check("R10", "aux after burst 1", 64'(aux_out), 64'(fb1));

    // R11: second trigger inside a burst is ignored
    trig_run(12, 1'b1, fb2);
    compare_words("R11 mid-burst trigger");
    check("R10", "aux after burst 2", 64'(aux_out), 64'(fb2));

    // R10: free mode keeps aux
    @(negedge clk); trig_mode = 1'b0;
    free_run(20, 0, 1'b0);
    compare_words("R10 free after bursts");
    check("R10", "aux held in free mode", 64'(aux_out), 64'(fb2));

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule